// File: doc/BRIEF.md
# Byte-Select External Memory Write Controller

This block turns a single internal byte write request into a write cycle on an external 16-bit memory bus that carries both address and data. A request is a 21-bit byte pointer, an 8-bit value and a mode bit. The controller first puts the low word-address bits on the shared lines and pulses an address-latch strobe so that an external latch can capture them. The upper address bits are held on their own outputs. The controller then copies the byte onto both halves of the bus and pulses the high write strobe once. The low write strobe is never used.

The memory receives only the word address, which is pointer bits 20:1. Pointer bit 0 picks the byte lane, and the mode bit sets how that lane is signalled. For a word-wide static RAM, one of two active-low half enables is asserted. For a word-wide Flash, both enables stay inactive, a byte-address line carries pointer bit 0, and a static select line puts the part in byte mode. Requests use a start/busy/done handshake. The pointer, the value and the mode are captured when a request is accepted.

Top module: `bytesel_wr_ctrl`

## Requirements
- R1: From the data setup cycle through the hold cycle, `adOut[15:8]` and `adOut[7:0]` both equal the captured byte.
- R2: Each write drives `wrhN` low exactly once, for STROBE_CYC consecutive cycles (default 2). `wrlN` is high at all times.
- R3: In SRAM mode (`flashMode`=0), pointer bit 0 = 0 drives `lbN` low with `ubN` high, and bit 0 = 1 drives `ubN` low with `lbN` high. The enable is held from the address cycle through the hold cycle, and both enables are high when idle.
- R4: In Flash mode (`flashMode`=1), `ubN` and `lbN` stay high, `baOut` equals pointer bit 0, and `byteWordN` is low. In SRAM mode `byteWordN` is high.
- R5: In the address cycle `aleOut` is high for exactly one cycle, `adOut` equals pointer bits 16:1, and `addrHi` equals pointer bits 20:17. `addrHi` holds that value through the whole transfer.
- R6: The phases run in this order: one address cycle, one setup cycle with `wrhN` high and data driven, STROBE_CYC strobe cycles, then one hold cycle with `wrhN` high and data still driven.
- R7: A start sampled high while idle is accepted. `busy` is high from the next cycle until the hold cycle ends. `done` is high only in the hold cycle. A start sampled while busy, including in the hold cycle, is ignored.
- R8: `adOe` is high only from the address cycle through the hold cycle. When `adOe` is low, `adOut` is zero.
- R9: The pointer, data and mode are captured at acceptance. Changing them during a transfer does not change any bus output of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Write request |
| ptrIn | input | 21 | Byte pointer |
| dataIn | input | 8 | Byte to write |
| flashMode | input | 1 | 1 = Flash signalling, 0 = SRAM signalling |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | High in the final (hold) cycle |
| adOut | output | 16 | Shared address/data lines |
| adOe | output | 1 | Output enable for adOut |
| addrHi | output | 4 | Upper address bits 20:17 |
| aleOut | output | 1 | Address latch strobe, active high |
| wrhN | output | 1 | High write strobe, active low |
| wrlN | output | 1 | Low write strobe, always inactive |
| ubN | output | 1 | Upper byte enable, active low |
| lbN | output | 1 | Lower byte enable, active low |
| baOut | output | 1 | Byte address (pointer bit 0) |
| byteWordN | output | 1 | Flash byte/word select, low = byte mode |

## Verification
A transfer's completion and a new request can fall in the same cycle: `done` is high in the hold cycle while `start` is already asserted. The bench holds `start` high through the hold cycle. It then checks that the next cycle is idle, with `busy`, `adOe` and `aleOut` low. It also checks that the request still asserted in that idle cycle starts a fresh address phase one cycle later, carrying the new pointer. Input changes made in the middle of a transfer are judged by comparing every bus output against the values captured at acceptance.

// File: rtl/bytesel_pkg.sv
package bytesel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchEn;    // capture request inputs
    logic driveAddr;  // put word address on shared lines
    logic driveData;  // put mirrored byte on shared lines
    logic ale;        // address latch strobe
    logic strobe;     // write strobe active
    logic laneEn;     // byte enables active window
  } ctrl_t;

endpackage

// File: rtl/bytesel_ctrl.sv
module bytesel_ctrl
  import bytesel_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);

  localparam int CW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

  phase_t phase, phaseNext;
  logic [CW-1:0] strobeCnt;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      ST_IDLE:   if (start) phaseNext = ST_ADDR;
      ST_ADDR:   phaseNext = ST_SETUP;
      ST_SETUP:  phaseNext = ST_STROBE;
      ST_STROBE: if (strobeCnt == LAST) phaseNext = ST_HOLD;
      ST_HOLD:   phaseNext = ST_IDLE;
      default:   phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      strobeCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == ST_STROBE) strobeCnt <= strobeCnt + 1'b1;
      else                    strobeCnt <= '0;
    end
  end

  always_comb begin
    ctrl.latchEn   = (phase == ST_IDLE) && start;
    ctrl.driveAddr = (phase == ST_ADDR);
    ctrl.driveData = (phase == ST_SETUP) || (phase == ST_STROBE) || (phase == ST_HOLD);
    ctrl.ale       = (phase == ST_ADDR);
    ctrl.strobe    = (phase == ST_STROBE);
    ctrl.laneEn    = (phase != ST_IDLE);
  end

  assign busy = (phase != ST_IDLE);
  assign done = (phase == ST_HOLD);

endmodule

// File: rtl/bytesel_datapath.sv
module bytesel_datapath
  import bytesel_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8,
  parameter int LANES  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_t                        ctrl,
  input  logic [PTR_W-1:0]             ptrIn,
  input  logic [DATA_W-1:0]            dataIn,
  input  logic                         flashMode,
  output logic [LANES*DATA_W-1:0]      adOut,
  output logic                         adOe,
  output logic [PTR_W-LANES*DATA_W-2:0] addrHi,
  output logic                         aleOut,
  output logic                         wrhN,
  output logic                         wrlN,
  output logic                         ubN,
  output logic                         lbN,
  output logic                         baOut,
  output logic                         byteWordN
);

  localparam int AD_W = LANES * DATA_W;

  logic [PTR_W-1:0]  ptrR;
  logic [DATA_W-1:0] dataR;
  logic              flashR;
  logic [AD_W-1:0]   mirror;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrR   <= '0;
      dataR  <= '0;
      flashR <= 1'b0;
    end else if (ctrl.latchEn) begin
      ptrR   <= ptrIn;
      dataR  <= dataIn;
      flashR <= flashMode;
    end
  end

  // Replicate the byte into every lane of the shared bus
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mirror[g*DATA_W +: DATA_W] = dataR;
  end

  always_comb begin
    if (ctrl.driveAddr)      adOut = ptrR[AD_W:1];
    else if (ctrl.driveData) adOut = mirror;
    else                     adOut = '0;
  end

  assign adOe      = ctrl.driveAddr | ctrl.driveData;
  assign addrHi    = ptrR[PTR_W-1:AD_W+1];
  assign aleOut    = ctrl.ale;
  assign wrhN      = ~ctrl.strobe;
  assign wrlN      = 1'b1;
  assign ubN       = ~(ctrl.laneEn & ~flashR &  ptrR[0]);
  assign lbN       = ~(ctrl.laneEn & ~flashR & ~ptrR[0]);
  assign baOut     = ptrR[0];
  assign byteWordN = ~flashR;

endmodule

// File: rtl/bytesel_wr_ctrl.sv
module bytesel_wr_ctrl
  import bytesel_pkg::*;
#(
  parameter int PTR_W      = 21,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [PTR_W-1:0]        ptrIn,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic                    flashMode,
  output logic                    busy,
  output logic                    done,
  output logic [2*DATA_W-1:0]     adOut,
  output logic                    adOe,
  output logic [PTR_W-2*DATA_W-2:0] addrHi,
  output logic                    aleOut,
  output logic                    wrhN,
  output logic                    wrlN,
  output logic                    ubN,
  output logic                    lbN,
  output logic                    baOut,
  output logic                    byteWordN
);

  ctrl_t ctrl;

  bytesel_ctrl #(.STROBE_CYC(STROBE_CYC)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  bytesel_datapath #(.PTR_W(PTR_W), .DATA_W(DATA_W), .LANES(2)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .ptrIn     (ptrIn),
    .dataIn    (dataIn),
    .flashMode (flashMode),
    .adOut     (adOut),
    .adOe      (adOe),
    .addrHi    (addrHi),
    .aleOut    (aleOut),
    .wrhN      (wrhN),
    .wrlN      (wrlN),
    .ubN       (ubN),
    .lbN       (lbN),
    .baOut     (baOut),
    .byteWordN (byteWordN)
  );

endmodule

// File: rtl/bytesel_checker.sv
module bytesel_checker #(
  parameter int PTR_W      = 21,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      start,
  input logic                      busy,
  input logic                      done,
  input logic [2*DATA_W-1:0]       adOut,
  input logic                      adOe,
  input logic [PTR_W-2*DATA_W-2:0] addrHi,
  input logic                      aleOut,
  input logic                      wrhN,
  input logic                      wrlN,
  input logic                      ubN,
  input logic                      lbN,
  input logic                      baOut,
  input logic                      byteWordN
);

  logic [31:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)      lowCnt <= '0;
    else if (!wrhN) lowCnt <= lowCnt + 1;
    else            lowCnt <= '0;
  end

  assert_low_unused_R2: assert property (@(posedge clk) disable iff (!rstN) wrlN);

  assert_strobe_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrhN) |-> lowCnt == STROBE_CYC);

  assert_mirror_R1: assert property (@(posedge clk) disable iff (!rstN)
    !wrhN |-> adOe && (adOut[2*DATA_W-1:DATA_W] == adOut[DATA_W-1:0]));

  assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~ubN, ~lbN}));

  assert_flash_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    !byteWordN |-> ubN && lbN);

  assert_ale_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> !aleOut && adOe && wrhN);

  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy && aleOut);

  assert_oe_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !adOe && ubN && lbN && wrhN);

  assert_captured_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrHi) && $stable(baOut) && $stable(byteWordN));

endmodule

bind bytesel_wr_ctrl bytesel_checker #(
  .PTR_W(PTR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .adOut(adOut), .adOe(adOe), .addrHi(addrHi), .aleOut(aleOut),
  .wrhN(wrhN), .wrlN(wrlN), .ubN(ubN), .lbN(lbN), .baOut(baOut),
  .byteWordN(byteWordN)
);

// File: tb/bytesel_wr_ctrl_test.sv
module bytesel_wr_ctrl_test;

  localparam int CLK_P      = 10;
  localparam int STROBE_CYC = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [20:0] ptrIn = '0;
  logic [7:0]  dataIn = '0;
  logic        flashMode = 1'b0;
  logic        busy, done, adOe, aleOut, wrhN, wrlN, ubN, lbN, baOut, byteWordN;
  logic [15:0] adOut;
  logic [3:0]  addrHi;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bytesel_wr_ctrl #(.PTR_W(21), .DATA_W(8), .STROBE_CYC(STROBE_CYC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .ptrIn(ptrIn), .dataIn(dataIn),
    .flashMode(flashMode), .busy(busy), .done(done), .adOut(adOut), .adOe(adOe),
    .addrHi(addrHi), .aleOut(aleOut), .wrhN(wrhN), .wrlN(wrlN), .ubN(ubN),
    .lbN(lbN), .baOut(baOut), .byteWordN(byteWordN)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    check(busy == 0 && done == 0, {tag, " R7 idle handshake"}, {busy, done}, 0);
    check(adOe == 0 && adOut == 0, {tag, " R8 bus released"}, {adOe, adOut}, 0);
    check(wrhN && wrlN && ubN && lbN && !aleOut, {tag, " R3 strobes idle"},
          {aleOut, wrhN, wrlN, ubN, lbN}, 5'b01111);
  endtask

  task automatic checkLanes(input logic [20:0] p, input bit fl, input string ph);
    logic expUb, expLb;
    expUb = fl ? 1'b1 : ~p[0];
    expLb = fl ? 1'b1 :  p[0];
    check(ubN == expUb && lbN == expLb, {ph, " R3 byte enables"}, {ubN, lbN}, {expUb, expLb});
    check(baOut == p[0] && byteWordN == ~fl, {ph, " R4 byte address/select"},
          {baOut, byteWordN}, {p[0], ~fl});
    check(addrHi == p[20:17], {ph, " R5 upper address"}, addrHi, p[20:17]);
  endtask

  // Entered at the negedge of the address cycle; leaves at the negedge of the hold cycle.
  task automatic checkPhases(input logic [20:0] p, input logic [7:0] d, input bit fl);
    check(aleOut && adOe && adOut == p[16:1], "R5 address phase", adOut, p[16:1]);
    check(busy && !done && wrhN, "R6 address cycle flags", {busy, done, wrhN}, 3'b101);
    checkLanes(p, fl, "addr");
    @(negedge clk);
    check(!aleOut && wrhN && adOe, "R6 setup cycle", {aleOut, wrhN, adOe}, 3'b011);
    check(adOut == {d, d}, "R1 setup mirror", adOut, {d, d});
    for (int i = 0; i < STROBE_CYC; i++) begin
      @(negedge clk);
      check(!wrhN && wrlN, "R2 strobe low", {wrhN, wrlN}, 2'b01);
      check(adOut == {d, d} && adOe, "R1 strobe mirror", adOut, {d, d});
      checkLanes(p, fl, "strobe");
    end
    @(negedge clk);
    check(wrhN && adOe && adOut == {d, d}, "R6 hold cycle data", adOut, {d, d});
    check(done && busy, "R7 done in hold", {done, busy}, 2'b11);
  endtask

  task automatic launch(input logic [20:0] p, input logic [7:0] d, input bit fl);
    @(negedge clk);
    start = 1'b1; ptrIn = p; dataIn = d; flashMode = fl;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    checkIdle("reset");
    check(byteWordN == 1'b1, "R4 reset select", byteWordN, 1);
  endtask

  task automatic testWrite(input logic [20:0] p, input logic [7:0] d, input bit fl);
    launch(p, d, fl);
    checkPhases(p, d, fl);
    @(negedge clk);
    checkIdle("after write");
  endtask

  task automatic testInputsChange();
    logic [20:0] p = 21'h0A_5A5B;
    logic [7:0]  d = 8'hC3;
    launch(p, d, 1'b0);
    ptrIn = ~p; dataIn = ~d; flashMode = 1'b1;  // R9 disturb mid-transfer
    checkPhases(p, d, 1'b0);
    @(negedge clk);
    checkIdle("R9 after disturbed write");
  endtask

  task automatic testStartAtDone();
    logic [20:0] p2 = 21'h1F_0F0E;
    launch(21'h00_1235, 8'h5A, 1'b0);
    start = 1'b1; ptrIn = 21'h00_1235; dataIn = 8'h5A;
    for (int i = 0; i < 2 + STROBE_CYC; i++) @(negedge clk);
    // now in hold cycle with start high
    check(done, "R7 hold with start high", done, 1);
    ptrIn = p2; dataIn = 8'h77; flashMode = 1'b1;
    @(negedge clk);
    check(!busy && !aleOut && !adOe, "R7 start during busy ignored",
          {busy, aleOut, adOe}, 0);
    @(negedge clk);
    start = 1'b0;
    checkPhases(p2, 8'h77, 1'b1);
    @(negedge clk);
    checkIdle("after back-to-back");
  endtask

  task automatic testNoStart();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!busy && !adOe && !aleOut, "R8 no request keeps bus idle", {busy, adOe, aleOut}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite(21'h12_3456, 8'hA5, 1'b0);   // SRAM even lane
    testWrite(21'h0F_FFFF, 8'h3C, 1'b0);   // SRAM odd lane
    testWrite(21'h1E_0002, 8'h81, 1'b1);   // Flash even
    testWrite(21'h01_0001, 8'hFF, 1'b1);   // Flash odd
    testWrite(21'h00_0000, 8'h00, 1'b0);   // all-zero pointer
    testInputsChange();
    testStartAtDone();
    testNoStart();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule